// File: doc/BRIEF.md
# Router Input Port with Overlapped Route Computation

This block is the input side of one port of a wormhole mesh router. Flits arrive with a valid/ready handshake and queue in a small FIFO. Route computation looks only at the flit at the front of that FIFO. A single-entry pipelined staging slot sits behind the FIFO. The request to the switch allocator, the grant and the crossbar traversal all use that slot. A route register holds the output direction of the packet currently crossing the port.

Because the staging slot and the FIFO front are separate, a new packet's head can be routed in the same cycle that the previous packet's tail is granted and leaves. Two packets that arrive back to back on one input therefore leave with no idle cycle between them. Routing is dimension-ordered: X is resolved first, then Y. The router's own coordinates are parameters.

Flit layout: bits [FLIT_W-1:FLIT_W-2] carry the kind: 00 body, 01 head, 10 tail, 11 single-flit packet. Bit 0 of the kind means "opens a packet" and bit 1 means "closes a packet". In an opening flit, bits [2:0] hold the destination X and bits [5:3] hold the destination Y.

Top module: `noc_inport`

## Requirements
- R1: While reset is held and right after it is released, in_ready is 1, sa_req is all zero and out_valid is 0.
- R2: The route comes from the front flit's destination. If dest X is greater than the router's X, the direction is east (3). If dest X is smaller, it is west (4). If the X values are equal, the direction is north (1) when dest Y is greater, south (2) when dest Y is smaller, and local (0) when both match. sa_req bit i stands for direction i, and out_dir carries the same code.
- R3: sa_req has at most one bit set. It is nonzero only while the staging slot holds a flit and a route is held.
- R4: out_valid is 1 exactly in cycles where sa_req is nonzero and sa_grant is 1. While the request is denied, the slot's flit and the request stay unchanged.
- R5: Flits leave in the order they were accepted, with none lost or duplicated.
- R6: With the grant held high, the opening flit of a packet that follows another on this input leaves in the cycle right after the previous closing flit.
- R7: When a closing flit leaves in the same cycle that a new opening flit is routed, the new route is kept, and the following packet uses it.
- R8: A single-flit packet (kind 11) both sets and clears the route. After it leaves with nothing behind it, sa_req returns to zero.
- R9: out_release is 1 exactly when a flit of kind tail or single-flit leaves.
- R10: in_ready is 0 while the FIFO is full. A flit offered while in_ready is 0 is not taken and never appears at the output.
- R11: A flit accepted at clock edge E, with the path ahead of it empty and the grant high, leaves in the cycle after edge E+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming flit valid |
| in_ready | output | 1 | FIFO can take a flit |
| in_flit | input | FLIT_W | Incoming flit |
| sa_req | output | NPORT | One-hot request to the switch allocator |
| sa_grant | input | 1 | Allocator grant for this input |
| out_valid | output | 1 | Flit crossing the switch this cycle |
| out_flit | output | FLIT_W | Flit in the staging slot |
| out_dir | output | 3 | Output direction of the flit |
| out_release | output | 1 | Packet end leaves; output port may be reused |

## Verification
The bench sends two multi-flit packets back to back to different directions with a permanent grant. This separates an overlapped design from one that leaves a bubble after each tail, and it shows whether the new route survives the tail's clear. A run with the grant held low fills the FIFO, then offers an extra flit. This exposes the backpressure, the hold of the request and the handling of flits offered while the FIFO is full. A burst of single-flit packets covers routing to several directions, and the case where one flit both sets and clears the route.

// File: rtl/noc_inport_pkg.sv
package noc_inport_pkg;

    localparam int NPORT = 5;

    typedef enum logic [2:0] {
        DIR_LOCAL = 3'd0,
        DIR_NORTH = 3'd1,
        DIR_SOUTH = 3'd2,
        DIR_EAST  = 3'd3,
        DIR_WEST  = 3'd4
    } dir_e;

    // kind bit 0: opens a packet, kind bit 1: closes a packet
    function automatic logic kind_opens(input logic [1:0] kind);
        return kind[0];
    endfunction

    function automatic logic kind_closes(input logic [1:0] kind);
        return kind[1];
    endfunction

endpackage

// File: rtl/inport_fifo.sv
module inport_fifo #(
    parameter int W     = 18,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         front_valid,
    output logic [W-1:0] front_data,
    output logic         not_full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PW:0] wr;
        logic [PW:0] rd;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop, empty, full;

    assign empty       = (ptr_q.wr == ptr_q.rd);
    assign full        = (ptr_q.wr[PW-1:0] == ptr_q.rd[PW-1:0]) && (ptr_q.wr[PW] != ptr_q.rd[PW]);
    assign not_full    = !full;
    assign front_valid = !empty;
    assign front_data  = mem[ptr_q.rd[PW-1:0]];
    assign do_push     = push && !full;
    assign do_pop      = pop && !empty;

    always_comb begin
        ptr_d = ptr_q;
        if (do_push) ptr_d.wr = ptr_q.wr + 1'b1;
        if (do_pop)  ptr_d.rd = ptr_q.rd + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[ptr_q.wr[PW-1:0]] <= push_data;
    end

endmodule

// File: rtl/xy_route.sv
module xy_route
    import noc_inport_pkg::*;
#(
    parameter int COORD_W = 3,
    parameter int MY_X    = 2,
    parameter int MY_Y    = 2
) (
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    output dir_e               dir
);
    localparam logic [COORD_W-1:0] HX = COORD_W'(MY_X);
    localparam logic [COORD_W-1:0] HY = COORD_W'(MY_Y);

    always_comb begin
        if (dst_x > HX)      dir = DIR_EAST;
        else if (dst_x < HX) dir = DIR_WEST;
        else if (dst_y > HY) dir = DIR_NORTH;
        else if (dst_y < HY) dir = DIR_SOUTH;
        else                 dir = DIR_LOCAL;
    end

endmodule

// File: rtl/noc_inport.sv
module noc_inport
    import noc_inport_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 4,
    parameter int COORD_W    = 3,
    parameter int MY_X       = 2,
    parameter int MY_Y       = 2,
    parameter int FLIT_W     = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [FLIT_W-1:0] in_flit,
    output logic [NPORT-1:0]  sa_req,
    input  logic              sa_grant,
    output logic              out_valid,
    output logic [FLIT_W-1:0] out_flit,
    output logic [2:0]        out_dir,
    output logic              out_release
);
    localparam int KIND_LSB = FLIT_W - 2;

    typedef struct packed {
        logic              slot_valid;
        logic [FLIT_W-1:0] slot_flit;
        logic              route_valid;
        dir_e              route;
    } state_t;

    state_t st_d, st_q;

    logic              front_valid;
    logic [FLIT_W-1:0] front_flit;
    logic [1:0]        front_kind, slot_kind;
    logic              slot_leave, slot_take, advance;
    dir_e              rc_dir;

    inport_fifo #(.W(FLIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (in_valid),
        .push_data  (in_flit),
        .pop        (advance),
        .front_valid(front_valid),
        .front_data (front_flit),
        .not_full   (in_ready)
    );

    xy_route #(.COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_rc (
        .dst_x(front_flit[COORD_W-1:0]),
        .dst_y(front_flit[2*COORD_W-1:COORD_W]),
        .dir  (rc_dir)
    );

    assign front_kind = front_flit[KIND_LSB +: 2];
    assign slot_kind  = st_q.slot_flit[KIND_LSB +: 2];
    assign slot_leave = st_q.slot_valid && st_q.route_valid && sa_grant;
    assign slot_take  = !st_q.slot_valid || slot_leave;
    assign advance    = front_valid && slot_take;

    always_comb begin
        st_d = st_q;
        if (advance) begin
            st_d.slot_valid = 1'b1;
            st_d.slot_flit  = front_flit;
        end else if (slot_leave) begin
            st_d.slot_valid = 1'b0;
        end
        // a new head's route takes priority over the old tail's clear
        if (advance && kind_opens(front_kind)) begin
            st_d.route_valid = 1'b1;
            st_d.route       = rc_dir;
        end else if (slot_leave && kind_closes(slot_kind)) begin
            st_d.route_valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{slot_valid: 1'b0, slot_flit: '0, route_valid: 1'b0, route: DIR_LOCAL};
        else        st_q <= st_d;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_req
        assign sa_req[p] = st_q.slot_valid && st_q.route_valid && (st_q.route == dir_e'(p));
    end

    assign out_valid   = slot_leave;
    assign out_flit    = st_q.slot_flit;
    assign out_dir     = st_q.route;
    assign out_release = slot_leave && kind_closes(slot_kind);

endmodule

// File: rtl/noc_inport_chk.sv
module noc_inport_chk #(
    parameter int FLIT_W = 18,
    parameter int NPORT  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPORT-1:0]  sa_req,
    input logic              sa_grant,
    input logic              out_valid,
    input logic [FLIT_W-1:0] out_flit,
    input logic              out_release
);
    a_r3_req_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sa_req));

    a_r4_leave_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (sa_grant && (sa_req != '0)));

    a_r4_leave_when_granted: assert property (@(posedge clk) disable iff (!rst_n)
        ((sa_req != '0) && sa_grant) |-> out_valid);

    a_r4_hold_when_denied: assert property (@(posedge clk) disable iff (!rst_n)
        ((sa_req != '0) && !sa_grant) |=> ((sa_req == $past(sa_req)) && $stable(out_flit)));

    a_r9_release_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_release == out_flit[FLIT_W-1]));

    a_r9_release_only_leaving: assert property (@(posedge clk) disable iff (!rst_n)
        out_release |-> out_valid);

endmodule

bind noc_inport noc_inport_chk #(.FLIT_W(FLIT_W), .NPORT(NPORT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sa_req     (sa_req),
    .sa_grant   (sa_grant),
    .out_valid  (out_valid),
    .out_flit   (out_flit),
    .out_release(out_release)
);

// File: tb/tb_noc_inport.sv
module tb_noc_inport;
    localparam int DW = 16;
    localparam int FW = DW + 2;
    localparam int NP = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [FW-1:0] in_flit = '0;
    logic [NP-1:0] sa_req;
    logic sa_grant = 1'b0;
    logic out_valid;
    logic [FW-1:0] out_flit;
    logic [2:0] out_dir;
    logic out_release;

    noc_inport #(.DATA_W(DW), .FIFO_DEPTH(4), .COORD_W(3), .MY_X(2), .MY_Y(2)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
        .sa_req(sa_req), .sa_grant(sa_grant), .out_valid(out_valid), .out_flit(out_flit),
        .out_dir(out_dir), .out_release(out_release)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    int nchk = 0;
    int nerr = 0;
    int n_log = 0;
    logic [FW-1:0] log_f [64];
    int            log_c [64];
    logic [2:0]    log_d [64];
    logic          log_r [64];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && out_valid && n_log < 64) begin
            log_f[n_log] <= out_flit;
            log_c[n_log] <= cyc;
            log_d[n_log] <= out_dir;
            log_r[n_log] <= out_release;
            n_log <= n_log + 1;
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            nerr = nerr + 1;
            $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 20000);
            $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
            $finish;
        end
    end

    function automatic logic [FW-1:0] mk(input logic [1:0] kind, input int x, input int y, input int tag);
        return {kind, 10'(tag), 3'(y), 3'(x)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [FW-1:0] f, output int acc);
        @(negedge clk);
        in_valid = 1'b1;
        in_flit  = f;
        while (!in_ready) @(negedge clk);
        acc = cyc;
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(in_ready == 1'b1, "R1 in_ready in reset", 32'(in_ready), 1);
        check(sa_req == '0, "R1 sa_req in reset", 32'(sa_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 0);
        check(sa_req == '0, "R1 sa_req after reset", 32'(sa_req), 0);
    endtask

    task automatic t_back_to_back();
        logic [FW-1:0] f [6];
        logic [2:0] d [6];
        int acc0, a;
        int base = n_log;
        f[0] = mk(2'b01, 4, 1, 1);  d[0] = 3; // east
        f[1] = mk(2'b00, 7, 7, 2);  d[1] = 3;
        f[2] = mk(2'b10, 0, 0, 3);  d[2] = 3;
        f[3] = mk(2'b01, 2, 5, 4);  d[3] = 1; // north
        f[4] = mk(2'b00, 1, 1, 5);  d[4] = 1;
        f[5] = mk(2'b10, 6, 6, 6);  d[5] = 1;
        sa_grant = 1'b1;
        send(f[0], acc0);
        for (int i = 1; i < 6; i++) send(f[i], a);
        idle(6);
        check(n_log - base == 6, "R5 flit count", 32'(n_log - base), 6);
        for (int i = 0; i < 6; i++) begin
            check(log_f[base+i] == f[i], "R5 flit order", 32'(log_f[base+i]), 32'(f[i]));
            check(log_d[base+i] == d[i], "R2/R7 direction", 32'(log_d[base+i]), 32'(d[i]));
            check(log_r[base+i] == (i == 2 || i == 5), "R9 release", 32'(log_r[base+i]), 32'(i == 2 || i == 5));
        end
        check(log_c[base] == acc0 + 2, "R11 head latency", 32'(log_c[base]), 32'(acc0 + 2));
        check(log_c[base+3] == log_c[base+2] + 1, "R6 second head after tail", 32'(log_c[base+3]), 32'(log_c[base+2] + 1));
        for (int i = 1; i < 6; i++)
            check(log_c[base+i] == log_c[base+i-1] + 1, "R6 no gap", 32'(log_c[base+i]), 32'(log_c[base+i-1] + 1));
        check(sa_req == '0, "R3 idle request", 32'(sa_req), 0);
    endtask

    task automatic t_stall();
        logic [FW-1:0] f [6];
        int a;
        int base = n_log;
        f[0] = mk(2'b01, 0, 5, 11); // west
        for (int i = 1; i < 5; i++) f[i] = mk(2'b00, i, i, 11 + i);
        f[5] = mk(2'b10, 3, 3, 17);
        sa_grant = 1'b0;
        for (int i = 0; i < 5; i++) send(f[i], a);
        @(negedge clk);
        in_valid = 1'b1;
        in_flit  = mk(2'b00, 5, 5, 99);
        check(in_ready == 1'b0, "R10 full drops ready", 32'(in_ready), 0);
        check(sa_req == 5'b10000, "R2/R3 west request held", 32'(sa_req), 32'h10);
        check(out_valid == 1'b0, "R4 no leave without grant", 32'(out_valid), 0);
        repeat (3) @(negedge clk);
        check(in_ready == 1'b0, "R10 still full", 32'(in_ready), 0);
        check(sa_req == 5'b10000, "R4 request stable while denied", 32'(sa_req), 32'h10);
        check(out_flit == f[0], "R4 slot flit stable", 32'(out_flit), 32'(f[0]));
        in_valid = 1'b0;
        sa_grant = 1'b1;
        send(f[5], a);
        idle(8);
        check(n_log - base == 6, "R10 offered flit not taken", 32'(n_log - base), 6);
        for (int i = 0; i < 6; i++) begin
            check(log_f[base+i] == f[i], "R5 order after stall", 32'(log_f[base+i]), 32'(f[i]));
            check(log_r[base+i] == (i == 5), "R9 release after stall", 32'(log_r[base+i]), 32'(i == 5));
        end
        check(sa_req == '0, "R8 route cleared after tail", 32'(sa_req), 0);
    endtask

    task automatic t_single();
        logic [FW-1:0] f [4];
        logic [2:0] d [4];
        int a;
        int base = n_log;
        f[0] = mk(2'b11, 2, 2, 21); d[0] = 0; // local
        f[1] = mk(2'b11, 2, 0, 22); d[1] = 2; // south
        f[2] = mk(2'b11, 4, 2, 23); d[2] = 3; // east
        f[3] = mk(2'b11, 1, 6, 24); d[3] = 4; // west (X first)
        sa_grant = 1'b1;
        for (int i = 0; i < 4; i++) send(f[i], a);
        idle(6);
        check(n_log - base == 4, "R8 single flit count", 32'(n_log - base), 4);
        for (int i = 0; i < 4; i++) begin
            check(log_f[base+i] == f[i], "R5 single order", 32'(log_f[base+i]), 32'(f[i]));
            check(log_d[base+i] == d[i], "R2 single direction", 32'(log_d[base+i]), 32'(d[i]));
            check(log_r[base+i] == 1'b1, "R8 single releases", 32'(log_r[base+i]), 1);
            if (i > 0)
                check(log_c[base+i] == log_c[base+i-1] + 1, "R7 back-to-back single", 32'(log_c[base+i]), 32'(log_c[base+i-1] + 1));
        end
        check(sa_req == '0, "R8 route cleared", 32'(sa_req), 0);
    endtask

    initial begin
        t_reset();
        t_back_to_back();
        t_stall();
        t_single();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule